// File: doc/BRIEF.md
# Converter Master Serial Output Framer

This block is the digital output side of a sampling converter that drives its own serial link. A one-cycle conversion-start pulse begins a conversion of fixed length, `CONV_CYC` clock cycles. At the end of the conversion a result stub supplies a word on `result_i`. The block divides its system clock by `DIV` to make a serial clock. It raises a sync strobe around each frame and shifts the word out most significant bit first. A busy flag tells the host whether the converter is working.

Two read timings are available. With `rd_mode_i` low, the word just converted is sent straight after the conversion ends, and busy stays high until the last bit has gone out. With `rd_mode_i` high, the frame starts together with the new conversion and carries the result of the conversion before it. In that case busy covers only the conversion. The very first frame of this kind after reset has no earlier result, so it carries zeros and raises `nodata_o`.

With `ext_sel_i` high, the block still converts but leaves the serial pins idle. The read mode and the select input are captured when a start is accepted. The two polarity inputs act directly on the clock and sync pins.

Top module: `conv_serial_framer`

## Requirements
- R1: After reset `busy_o` is 0, `sdata_o` is 0 and `nodata_o` is 0. `sclk_o` equals `sclk_inv_i` and `sync_o` equals `sync_inv_i`, which are their inactive levels.
- R2: A frame has exactly 16 serial clock pulses. Each pulse is DIV system cycles long: low for the first half and high for the second, before inversion. Bit 15 of the word goes out first and bit 0 last. Data changes only while the un-inverted clock is low, so it is valid on each rising edge.
- R3: The un-inverted sync is high for exactly 16*DIV consecutive cycles per frame. Whenever sync is inactive, `sdata_o` is 0 and the un-inverted clock is low.
- R4: `sclk_o` is the internal clock XOR `sclk_inv_i`, and `sync_o` is the internal sync XOR `sync_inv_i`.
- R5: With `rd_mode_i`=0, counting the first busy cycle as 0, sync first goes active in cycle CONV_CYC and the frame carries that conversion's `result_i`. `busy_o` is high for CONV_CYC+16*DIV cycles and falls when sync ends.
- R6: With `rd_mode_i`=1, sync goes active in the first busy cycle and the frame carries the result of the previous conversion. `busy_o` is high for CONV_CYC cycles.
- R7: The first `rd_mode_i`=1 frame after reset carries 0x0000. For that frame, `nodata_o` is high for exactly its 16*DIV cycles; it is 0 at all other times.
- R8: With `ext_sel_i`=1 at start, no frame is sent: sync and clock stay at their inactive levels and data stays 0. `busy_o` is high for CONV_CYC cycles, and the result is still kept as the previous result.
- R9: A start pulse is ignored while `busy_o` is high or a frame is still being sent. It changes neither busy, nor the frame, nor the stored previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion-start pulse |
| ext_sel_i | input | 1 | 1 = serial outputs idle (external-clock mode) |
| rd_mode_i | input | 1 | 0 = read after conversion, 1 = read previous during conversion |
| sclk_inv_i | input | 1 | Invert the serial clock output |
| sync_inv_i | input | 1 | Invert the sync output |
| result_i | input | W | Result word from the conversion stub, sampled at conversion end |
| busy_o | output | 1 | Conversion (and, in mode 0, readout) in progress |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Frame-valid strobe |
| sdata_o | output | 1 | Serial data, MSB first |
| nodata_o | output | 1 | Current frame carries no earlier result |

## Verification
The bench builds the block with CONV_CYC=5 and DIV=4. A mode-0 transfer then takes under 80 cycles, which makes it cheap to sweep both read modes, both polarity bits of each output and 18 data patterns. The patterns are every walking one, all ones and one mixed word. Because the conversion is shorter than the frame, read-during-conversion frames outlive busy. This exposes the rule that a start is refused while a frame is still running. Start pulses are also injected while busy is high. Resets place first-frame and external-select cases at chosen points in the sequence.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_CONV  = 2'd1,
        CTL_DRAIN = 2'd2
    } ctl_st_e;

    typedef struct packed {
        ctl_st_e st;
        logic    mode;
        logic    ext;
        logic    prev_vld;
    } ctl_t;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic done_o
);
    localparam int CW = $clog2(CONV_CYC + 1);

    logic          run_d, run_q;
    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = run_q && (cnt_q == CW'(CONV_CYC - 1));

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (go_i) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (run_q) begin
            if (done_o) run_d = 1'b0;
            else        cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    // R9
    start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !run_q);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int W   = 16,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         nod_i,
    output logic         act_o,
    output logic         sclk_o,
    output logic         sdata_o,
    output logic         last_o,
    output logic         nod_o
);
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int BW   = $clog2(W);
    localparam int HALF = DIV / 2;

    logic          act_d, act_q;
    logic          nod_d, nod_q;
    logic [PW-1:0] ph_d, ph_q;
    logic [BW-1:0] bit_d, bit_q;
    logic [W-1:0]  sh_d, sh_q;

    logic wrap;
    assign wrap    = (ph_q == PW'(DIV - 1));
    assign act_o   = act_q;
    assign sclk_o  = act_q && (ph_q >= PW'(HALF));
    assign sdata_o = act_q && sh_q[W-1];
    assign last_o  = act_q && wrap && (bit_q == BW'(W - 1));
    assign nod_o   = nod_q;

    always_comb begin
        act_d = act_q;
        nod_d = nod_q;
        ph_d  = ph_q;
        bit_d = bit_q;
        sh_d  = sh_q;
        if (load_i) begin
            act_d = 1'b1;
            nod_d = nod_i;
            ph_d  = '0;
            bit_d = '0;
            sh_d  = word_i;
        end else if (act_q) begin
            if (wrap) begin
                ph_d = '0;
                if (last_o) begin
                    act_d = 1'b0;
                    nod_d = 1'b0;
                    sh_d  = '0;
                end else begin
                    bit_d = bit_q + BW'(1);
                    sh_d  = {sh_q[W-2:0], 1'b0};
                end
            end else begin
                ph_d = ph_q + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            nod_q <= 1'b0;
            ph_q  <= '0;
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            act_q <= act_d;
            nod_q <= nod_d;
            ph_q  <= ph_d;
            bit_q <= bit_d;
            sh_q  <= sh_d;
        end
    end

    // R2
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !$stable(sdata_o)) |-> !sclk_o);

    // R3
    load_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !act_q);
endmodule

// File: rtl/conv_serial_framer.sv
module conv_serial_framer
    import cnv_pkg::*;
#(
    parameter int W        = 16,
    parameter int CONV_CYC = 40,
    parameter int DIV      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ext_sel_i,
    input  logic         rd_mode_i,
    input  logic         sclk_inv_i,
    input  logic         sync_inv_i,
    input  logic [W-1:0] result_i,
    output logic         busy_o,
    output logic         sclk_o,
    output logic         sync_o,
    output logic         sdata_o,
    output logic         nodata_o
);
    ctl_t         ctl_d, ctl_q;
    logic [W-1:0] prev_d, prev_q;

    logic         accept, t_done;
    logic         ld, ld_nod;
    logic [W-1:0] ld_word;
    logic         f_act, f_sclk, f_sdata, f_last, f_nod;

    assign accept = start_i && (ctl_q.st == CTL_IDLE) && !f_act;
    assign busy_o = (ctl_q.st != CTL_IDLE);

    conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (accept),
        .done_o (t_done)
    );

    frame_shifter #(.W(W), .DIV(DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .word_i  (ld_word),
        .nod_i   (ld_nod),
        .act_o   (f_act),
        .sclk_o  (f_sclk),
        .sdata_o (f_sdata),
        .last_o  (f_last),
        .nod_o   (f_nod)
    );

    always_comb begin
        ctl_d   = ctl_q;
        prev_d  = prev_q;
        ld      = 1'b0;
        ld_nod  = 1'b0;
        ld_word = '0;
        unique case (ctl_q.st)
            CTL_IDLE: begin
                if (accept) begin
                    ctl_d.st   = CTL_CONV;
                    ctl_d.mode = rd_mode_i;
                    ctl_d.ext  = ext_sel_i;
                    if (rd_mode_i && !ext_sel_i) begin
                        ld      = 1'b1;
                        ld_nod  = !ctl_q.prev_vld;
                        ld_word = ctl_q.prev_vld ? prev_q : '0;
                    end
                end
            end
            CTL_CONV: begin
                if (t_done) begin
                    prev_d         = result_i;
                    ctl_d.prev_vld = 1'b1;
                    if (!ctl_q.mode && !ctl_q.ext) begin
                        ld       = 1'b1;
                        ld_word  = result_i;
                        ctl_d.st = CTL_DRAIN;
                    end else begin
                        ctl_d.st = CTL_IDLE;
                    end
                end
            end
            CTL_DRAIN: begin
                if (f_last) ctl_d.st = CTL_IDLE;
            end
            default: ctl_d.st = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{st: CTL_IDLE, mode: 1'b0, ext: 1'b0, prev_vld: 1'b0};
            prev_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            prev_q <= prev_d;
        end
    end

    assign sclk_o   = f_sclk ^ sclk_inv_i;
    assign sync_o   = f_act ^ sync_inv_i;
    assign sdata_o  = f_sdata;
    assign nodata_o = f_nod;

    // R5
    drain_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == CTL_DRAIN) |-> f_act);

    // R8
    ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.ext) |-> !f_act);

    // R7
    nodata_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nodata_o |-> (f_act && ctl_q.mode));
endmodule

// File: tb/conv_serial_framer_tb.sv
module conv_serial_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int CONV  = 5;
    localparam int DIV   = 4;
    localparam int FRAME = 16 * DIV;
    localparam int WIN   = CONV + FRAME + 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, ext_sel_i = 1'b0, rd_mode_i = 1'b0;
    logic         sclk_inv_i = 1'b0, sync_inv_i = 1'b0;
    logic [W-1:0] result_i = '0;
    logic         busy_o, sclk_o, sync_o, sdata_o, nodata_o;

    int  n_run = 0, n_fail = 0;
    bit  finished = 0;
    logic [W-1:0] prev_word = '0;
    bit  prev_vld = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_serial_framer #(.W(W), .CONV_CYC(CONV), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_sel_i(ext_sel_i),
        .rd_mode_i(rd_mode_i), .sclk_inv_i(sclk_inv_i), .sync_inv_i(sync_inv_i),
        .result_i(result_i), .busy_o(busy_o), .sclk_o(sclk_o), .sync_o(sync_o),
        .sdata_o(sdata_o), .nodata_o(nodata_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prev_vld = 0;
        prev_word = '0;
        @(negedge clk);
    endtask

    task automatic idle_chk(input string tag);
        chk(busy_o == 1'b0, {tag, " busy idle"}, int'(busy_o), 0);
        chk(sclk_o == sclk_inv_i, {tag, " sclk idle"}, int'(sclk_o), int'(sclk_inv_i));
        chk(sync_o == sync_inv_i, {tag, " sync idle"}, int'(sync_o), int'(sync_inv_i));
        chk(sdata_o == 1'b0, {tag, " data idle"}, int'(sdata_o), 0);
        chk(nodata_o == 1'b0, {tag, " nodata idle"}, int'(nodata_o), 0);
    endtask

    // One transfer; glitch >= 0 pulses start again after sample index glitch.
    task automatic xfer(input bit mode, input bit ext, input logic [W-1:0] word,
                        input int glitch);
        int busy_n = 0, sync_n = 0, pulses = 0, first = -1, nod_n = 0, stray = 0;
        bit prev_c = 0;
        logic [W-1:0] cap = '0;
        logic [W-1:0] exp_word;
        int exp_busy, exp_sync, exp_pulse, exp_first, exp_nod;

        exp_word  = mode ? (prev_vld ? prev_word : '0) : word;
        exp_busy  = (!mode && !ext) ? CONV + FRAME : CONV;
        exp_sync  = ext ? 0 : FRAME;
        exp_pulse = ext ? 0 : 16;
        exp_first = ext ? -1 : (mode ? 0 : CONV);
        exp_nod   = (mode && !ext && !prev_vld) ? FRAME : 0;

        rd_mode_i = mode;
        ext_sel_i = ext;
        result_i  = word;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            bit rc, rs;
            rc = sclk_o ^ sclk_inv_i;
            rs = sync_o ^ sync_inv_i;
            if (busy_o) busy_n++;
            if (rs) begin
                sync_n++;
                if (first < 0) first = i;
            end
            if (nodata_o) nod_n++;
            if (!rs && (sdata_o || rc)) stray++;
            if (rc && !prev_c) begin
                pulses++;
                cap = {cap[W-2:0], sdata_o};
            end
            prev_c = rc;
            start_i = (i == glitch);
            @(negedge clk);
        end
        start_i = 1'b0;

        chk(busy_n == exp_busy, mode ? "R6 busy length" : (ext ? "R8 busy length" : "R5 busy length"), busy_n, exp_busy);
        chk(sync_n == exp_sync, ext ? "R8 sync idle" : "R3 sync length", sync_n, exp_sync);
        chk(pulses == exp_pulse, ext ? "R8 clock idle" : "R2 pulse count", pulses, exp_pulse);
        chk(first == exp_first, mode ? "R6 frame start" : "R5 frame start", first, exp_first);
        chk(stray == 0, "R3 data/clock outside frame", stray, 0);
        chk(nod_n == exp_nod, "R7 nodata length", nod_n, exp_nod);
        if (!ext)
            chk(cap == exp_word, mode ? "R6 previous word" : "R5/R2 word", int'(cap), int'(exp_word));
        if (glitch >= 0)
            chk(busy_n == exp_busy && sync_n == exp_sync, "R9 start ignored", busy_n + sync_n, exp_busy + exp_sync);
        idle_chk("R4 after frame");

        prev_word = word;
        prev_vld  = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle_chk("R1 reset");
        sclk_inv_i = 1'b1;
        sync_inv_i = 1'b1;
        @(negedge clk);
        chk(sclk_o == 1'b1, "R4 sclk inverted idle", int'(sclk_o), 1);
        chk(sync_o == 1'b1, "R4 sync inverted idle", int'(sync_o), 1);
        sclk_inv_i = 1'b0;
        sync_inv_i = 1'b0;

        // R7: first read-during-conversion frame after reset
        xfer(1'b1, 1'b0, 16'hBEEF, -1);
        xfer(1'b1, 1'b0, 16'h1234, -1);

        // R2, R4, R5, R6 sweep
        for (int m = 0; m < 2; m++)
            for (int ci = 0; ci < 2; ci++)
                for (int si = 0; si < 2; si++)
                    for (int k = 0; k < 18; k++) begin
                        logic [W-1:0] w;
                        w = (k < 16) ? (W'(1) << k) : ((k == 16) ? 16'hFFFF : 16'hA5C3);
                        sclk_inv_i = ci[0];
                        sync_inv_i = si[0];
                        xfer(m[0], 1'b0, w, -1);
                    end

        // R8: external select keeps pins idle but result is still stored
        sclk_inv_i = 1'b1;
        sync_inv_i = 1'b0;
        xfer(1'b0, 1'b1, 16'h0F0F, -1);
        xfer(1'b1, 1'b1, 16'h3C3C, -1);
        sclk_inv_i = 1'b0;
        sync_inv_i = 1'b1;
        xfer(1'b1, 1'b0, 16'h7777, -1);

        // R9: starts while busy or while a frame is still running
        sclk_inv_i = 1'b0;
        sync_inv_i = 1'b0;
        xfer(1'b0, 1'b0, 16'h8001, 1);
        xfer(1'b0, 1'b0, 16'h4002, CONV + 2);
        xfer(1'b1, 1'b0, 16'h2004, 2);
        xfer(1'b1, 1'b0, 16'h1008, CONV + 2);
        xfer(1'b1, 1'b0, 16'h0000, -1);

        // R7 again after a fresh reset, R5 then R6 with valid history
        do_reset();
        idle_chk("R1 second reset");
        xfer(1'b0, 1'b0, 16'hC001, -1);
        xfer(1'b1, 1'b0, 16'h5555, -1);
        do_reset();
        xfer(1'b1, 1'b1, 16'h6666, -1);
        xfer(1'b1, 1'b0, 16'h9999, -1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule